// File: doc/BRIEF.md
# DDR SDRAM Refresh Command Sequencer

This block sits between a memory controller's scheduler and the DDR SDRAM command pins. When the scheduler asks for a periodic refresh, the block takes over the command bus. It always first issues a precharge slot, with A10 high when a bank may be open. It waits the row-precharge time and then issues the REFRESH. After that it drives only NOPs until the refresh cycle time has run out. If the scheduler still holds its request when that window closes, the block chains a further REFRESH directly, without another precharge.

A level-sensitive self-refresh request, accepted only while every bank is closed, puts the device into self refresh. The block drives a REFRESH encoding in the same cycle that CKE falls. It keeps CKE low for as long as the request stays high. Once the request is dropped and the clock is reported stable, CKE is raised and NOPs fill the exit window. The block then issues a mode/DLL reset command. A "reads allowed" flag stays low from self-refresh entry until a fixed number of clocks after that DLL reset.

All timing windows are whole clock cycles set by parameters. The scheduler sees a one-cycle grant when its request is taken and a busy level while the sequencer owns the bus.

Top module: `ddr_refresh_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle: CKE high, NOP (0111 on CS#/RAS#/CAS#/WE#) on the command bus, busy and grant low, reads allowed high.
- R2: In idle with `ref_req` high, grant is high in that same cycle. In the next cycle the command is PRECHARGE (0010) with busy high. A10 is 1 if `bank_open` was high when the request was taken, and 0 otherwise.
- R3: REFRESH (0001) appears exactly T_RP cycles after the PRECHARGE, with NOPs in every cycle between them.
- R4: After an auto REFRESH, the next T_RFC-1 cycles are NOPs. In the cycle after them, the block issues another REFRESH if `ref_req` was high in the last NOP cycle, and otherwise returns to idle.
- R5: CKE stays high in every cycle from the PRECHARGE through the end of the last refresh window.
- R6: Busy is high from the PRECHARGE through the last cycle of the final timing window, and grant is only ever high while busy is low. A request raised while busy is high is not granted and has no later effect.
- R7: In idle with `sr_req` high, `bank_open` low and `ref_req` low, grant is high. The next cycle carries REFRESH (0001) with CKE low. If `bank_open` is high, the self-refresh request is not granted and the bus stays at NOP with CKE high.
- R8: CKE stays low while `sr_req` stays high, or while `clk_stable` is low. It rises in the cycle after an edge that sees `sr_req` low and `clk_stable` high.
- R9: From the cycle in which CKE rises, T_XSNR cycles of NOP follow. The next cycle carries the mode/DLL reset command (0000), and the block is idle in the cycle after that.
- R10: Reads allowed is low from the self-refresh REFRESH cycle onward. It is still low DLL_LOCK-1 cycles after the DLL reset cycle, and high DLL_LOCK cycles after it.
- R11: When `ref_req` and `sr_req` are both high in idle, the auto-refresh sequence wins: a PRECHARGE with CKE high follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_req | input | 1 | Scheduler asks for an auto refresh (held high to chain another) |
| sr_req | input | 1 | Level request to be in self refresh |
| bank_open | input | 1 | At least one bank may be open |
| clk_stable | input | 1 | Memory clock is stable; self-refresh exit may begin |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_a10 | output | 1 | Address bit 10 (all-banks select on precharge) |
| mem_cke | output | 1 | Clock enable |
| grant | output | 1 | One-cycle acceptance of a request |
| busy | output | 1 | Sequencer owns the command bus |
| reads_ok | output | 1 | DLL relocked; READ commands may be issued |

## Verification
On every cycle the assertions check the following. The NOP-only, CKE-high window after each auto REFRESH. That CKE only falls together with a REFRESH encoding and only rises after a stable-clock, request-released edge. That a precharge taken with a bank open carries A10 high. That grant never overlaps busy. That reads stay blocked right after a DLL reset. The exact distances need the bench's scenarios: precharge to refresh, CKE rise to DLL reset, and DLL reset to reads allowed. So do the chaining of back-to-back refreshes, the refusal of self refresh with an open bank, the priority of refresh over self refresh, and the dropping of requests made while busy.

// File: rtl/ddr_ref_pkg.sv
// Package: shared command encodings and sequencer states.
// Assumes the command bus order {CS#, RAS#, CAS#, WE#}.
package ddr_ref_pkg;

    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_INHIB = 4'b1111
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_RP_WAIT,
        ST_REF,
        ST_RFC_WAIT,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_DLL_RST
    } seq_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
// Module: ref_interval_timer
// Down-counter shared by all timing windows. A load sets the count and
// expired is high while the count is zero.
// Assumes the controlling FSM loads it on entry to each wait state.
module ref_interval_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count_q;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/dll_lock_tracker.sv
// Module: dll_lock_tracker
// Tracks whether READs may be issued. Clear drops the flag on self-refresh
// entry. Start, asserted in the DLL reset cycle, raises the flag again
// LOCK_CYCLES cycles later.
// Assumes LOCK_CYCLES >= 2 and that the DLL is locked after reset.
module dll_lock_tracker #(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic locked
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] count_q;
    logic          locked_q;

    // Count the relock interval and set the flag when it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
            count_q  <= '0;
        end else if (clear) begin
            locked_q <= 1'b0;
            count_q  <= '0;
        end else if (start) begin
            count_q  <= CW'(LOCK_CYCLES - 1);
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
            if (count_q == CW'(1)) begin
                locked_q <= 1'b1;
            end
        end
    end

    assign locked = locked_q;

endmodule

// File: rtl/ref_seq_fsm.sv
// Module: ref_seq_fsm
// Control state machine. It decides which command goes on the bus, loads
// the shared timer for each window, and tells the DLL tracker when self
// refresh starts and when the DLL reset is sent. Outputs are decoded from
// the state register.
// Assumes T_RP, T_RFC and T_XSNR are at least 2.
module ref_seq_fsm
    import ddr_ref_pkg::*;
#(
    parameter int T_RP   = 3,
    parameter int T_RFC  = 8,
    parameter int T_XSNR = 10,
    parameter int W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_req,
    input  logic         sr_req,
    input  logic         bank_open,
    input  logic         clk_stable,
    input  logic         tmr_expired,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         dll_clear,
    output logic         dll_start,
    output logic [3:0]   cmd,
    output logic         a10,
    output logic         cke,
    output logic         grant,
    output logic         busy
);

    seq_state_e state_q, state_d;
    logic       a10_all_q;

    // Next-state, timer-load and handshake decisions.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        grant     = 1'b0;
        dll_clear = 1'b0;
        dll_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req) begin
                    grant   = 1'b1;
                    state_d = ST_PRE;
                end else if (sr_req && !bank_open) begin
                    grant     = 1'b1;
                    dll_clear = 1'b1;
                    state_d   = ST_SR_ENTER;
                end
            end
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = W'(T_RP - 2);
                state_d  = ST_RP_WAIT;
            end
            ST_RP_WAIT: begin
                if (tmr_expired) state_d = ST_REF;
            end
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = W'(T_RFC - 2);
                state_d  = ST_RFC_WAIT;
            end
            ST_RFC_WAIT: begin
                if (tmr_expired) state_d = ref_req ? ST_REF : ST_IDLE;
            end
            ST_SR_ENTER: begin
                state_d = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (!sr_req && clk_stable) begin
                    tmr_load = 1'b1;
                    tmr_val  = W'(T_XSNR - 1);
                    state_d  = ST_SR_EXIT;
                end
            end
            ST_SR_EXIT: begin
                if (tmr_expired) state_d = ST_DLL_RST;
            end
            ST_DLL_RST: begin
                dll_start = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the all-banks choice when an auto refresh is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a10_all_q <= 1'b0;
        end else if (state_q == ST_IDLE && ref_req) begin
            a10_all_q <= bank_open;
        end
    end

    // Command, A10, CKE and busy decode from the current state.
    always_comb begin
        cmd  = CMD_NOP;
        a10  = 1'b0;
        cke  = 1'b1;
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PRE: begin
                cmd = CMD_PRE;
                a10 = a10_all_q;
            end
            ST_REF:      cmd = CMD_REF;
            ST_SR_ENTER: begin
                cmd = CMD_REF;
                cke = 1'b0;
            end
            ST_SR_HOLD:  cke = 1'b0;
            ST_DLL_RST:  cmd = CMD_MODE;
            default:     cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr_refresh_sequencer.sv
// Module: ddr_refresh_sequencer (top)
// Issues auto-refresh sequences and manages self-refresh entry and exit on
// a DDR SDRAM command bus, and gates READs until the DLL has relocked.
// Assumes every timing parameter is a whole number of cycles >= 2.
module ddr_refresh_sequencer #(
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10,
    parameter int T_XSNR   = 12,
    parameter int DLL_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_req,
    input  logic sr_req,
    input  logic bank_open,
    input  logic clk_stable,
    output logic mem_cs_n,
    output logic mem_ras_n,
    output logic mem_cas_n,
    output logic mem_we_n,
    output logic mem_a10,
    output logic mem_cke,
    output logic grant,
    output logic busy,
    output logic reads_ok
);

    localparam int MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_T = (MAX_A > T_XSNR) ? MAX_A : T_XSNR;
    localparam int TW    = $clog2(MAX_T + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          dll_clear;
    logic          dll_start;
    logic [3:0]    cmd;

    ref_seq_fsm #(
        .T_RP   (T_RP),
        .T_RFC  (T_RFC),
        .T_XSNR (T_XSNR),
        .W      (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_req     (ref_req),
        .sr_req      (sr_req),
        .bank_open   (bank_open),
        .clk_stable  (clk_stable),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .dll_clear   (dll_clear),
        .dll_start   (dll_start),
        .cmd         (cmd),
        .a10         (mem_a10),
        .cke         (mem_cke),
        .grant       (grant),
        .busy        (busy)
    );

    ref_interval_timer #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dll_lock_tracker #(
        .LOCK_CYCLES (DLL_LOCK)
    ) u_dll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (dll_clear),
        .start  (dll_start),
        .locked (reads_ok)
    );

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

endmodule

// File: rtl/ddr_refresh_sequencer_checker.sv
// Module: ddr_refresh_sequencer_checker
// Protocol checks on the sequencer's ports, bound into every instance.
module ddr_refresh_sequencer_checker #(
    parameter int T_RFC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic sr_req,
    input logic bank_open,
    input logic clk_stable,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic mem_a10,
    input logic mem_cke,
    input logic grant,
    input logic busy,
    input logic reads_ok
);

    localparam int CW = $clog2(T_RFC + 1);

    logic [3:0]    cmd;
    logic [CW-1:0] rfc_left;

    assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    // Track the NOP window that follows each auto REFRESH.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rfc_left <= '0;
        else if (cmd == 4'b0001 && mem_cke)    rfc_left <= CW'(T_RFC - 1);
        else if (rfc_left != '0)               rfc_left <= rfc_left - 1'b1;
    end

    // R4 R5: only NOPs with CKE high inside the refresh window.
    p_rfc_nop_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rfc_left != '0) |-> (cmd == 4'b0111 && mem_cke));

    // R2: a precharge taken with a bank open selects all banks.
    p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010 && $past(bank_open) && !$past(busy)) |-> mem_a10);

    // R7: CKE only falls together with a REFRESH encoding.
    p_sr_entry_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cke) |-> (cmd == 4'b0001));

    // R8: CKE only rises after the request is released with a stable clock.
    p_sr_exit_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cke) |-> ($past(clk_stable) && !$past(sr_req)));

    // R6: grant never overlaps busy.
    p_grant_idle_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !busy);

    // R6: a precharge is always part of a busy sequence.
    p_pre_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> busy);

    // R10: reads stay blocked right after a DLL reset.
    p_reads_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |=> !reads_ok);

endmodule

bind ddr_refresh_sequencer ddr_refresh_sequencer_checker #(
    .T_RFC (T_RFC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_req     (sr_req),
    .bank_open  (bank_open),
    .clk_stable (clk_stable),
    .mem_cs_n   (mem_cs_n),
    .mem_ras_n  (mem_ras_n),
    .mem_cas_n  (mem_cas_n),
    .mem_we_n   (mem_we_n),
    .mem_a10    (mem_a10),
    .mem_cke    (mem_cke),
    .grant      (grant),
    .busy       (busy),
    .reads_ok   (reads_ok)
);

// File: tb/ddr_refresh_sequencer_bench.sv
// Bench: table-driven refresh scenarios, then directed self-refresh,
// priority, ignore and reset tests.
module ddr_refresh_sequencer_bench;

    localparam int T_RP     = 3;
    localparam int T_RFC    = 6;
    localparam int T_XSNR   = 4;
    localparam int DLL_LOCK = 200;

    localparam logic [3:0] C_MODE = 4'b0000;
    localparam logic [3:0] C_REF  = 4'b0001;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_NOP  = 4'b0111;

    // Each entry: {bank_open, refresh count (2 bits), expected A10}.
    localparam logic [3:0] VEC [0:3] = '{4'b1_01_1, 4'b0_01_0, 4'b1_10_1, 4'b0_11_0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_req = 1'b0;
    logic sr_req = 1'b0;
    logic bank_open = 1'b0;
    logic clk_stable = 1'b1;
    logic cs_n, ras_n, cas_n, we_n, a10, cke, grant, busy, reads_ok;
    logic [3:0] cmd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    ddr_refresh_sequencer #(
        .T_RP     (T_RP),
        .T_RFC    (T_RFC),
        .T_XSNR   (T_XSNR),
        .DLL_LOCK (DLL_LOCK)
    ) u_ddr_refresh_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_req    (ref_req),
        .sr_req     (sr_req),
        .bank_open  (bank_open),
        .clk_stable (clk_stable),
        .mem_cs_n   (cs_n),
        .mem_ras_n  (ras_n),
        .mem_cas_n  (cas_n),
        .mem_we_n   (we_n),
        .mem_a10    (a10),
        .mem_cke    (cke),
        .grant      (grant),
        .busy       (busy),
        .reads_ok   (reads_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    endtask

    // Run one auto-refresh sequence with nref chained refreshes.
    task automatic run_refresh(input logic open, input int nref, input logic ea10);
        @(negedge clk);
        ref_req = 1'b1;
        bank_open = open;
        #1 check(grant == 1'b1, "R2 grant", int'(grant), 1);
        @(negedge clk);
        check(cmd == C_PRE, "R2 precharge", int'(cmd), int'(C_PRE));
        check(a10 == ea10, "R2 a10", int'(a10), int'(ea10));
        check(busy == 1'b1, "R6 busy", int'(busy), 1);
        bank_open = 1'b0;
        for (int i = 1; i < T_RP; i++) begin
            @(negedge clk);
            check(cmd == C_NOP, "R3 nop", int'(cmd), int'(C_NOP));
            check(cke == 1'b1, "R5 cke", int'(cke), 1);
        end
        @(negedge clk);
        check(cmd == C_REF, "R3 refresh", int'(cmd), int'(C_REF));
        check(cke == 1'b1, "R5 cke", int'(cke), 1);
        for (int k = 0; k < nref; k++) begin
            for (int j = 1; j < T_RFC; j++) begin
                @(negedge clk);
                check(cmd == C_NOP, "R4 nop", int'(cmd), int'(C_NOP));
                check(cke == 1'b1, "R5 cke", int'(cke), 1);
                check(busy == 1'b1, "R6 busy", int'(busy), 1);
                if (j == T_RFC - 1) ref_req = (k < nref - 1);
            end
            @(negedge clk);
            if (k < nref - 1) begin
                check(cmd == C_REF, "R4 chained refresh", int'(cmd), int'(C_REF));
            end else begin
                check(cmd == C_NOP, "R4 idle nop", int'(cmd), int'(C_NOP));
                check(busy == 1'b0, "R6 busy low", int'(busy), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cke == 1'b1, "R1 cke", int'(cke), 1);
        check(cmd == C_NOP, "R1 cmd", int'(cmd), int'(C_NOP));
        check(busy == 1'b0 && grant == 1'b0, "R1 busy/grant", int'(busy), 0);
        check(reads_ok == 1'b1, "R1 reads_ok", int'(reads_ok), 1);
        rst_n = 1'b1;

        // R2 R3 R4 R5: table of refresh scenarios
        for (int v = 0; v < 4; v++) begin
            run_refresh(VEC[v][3], int'(VEC[v][2:1]), VEC[v][0]);
        end

        // R6: a request raised while busy is dropped
        @(negedge clk); ref_req = 1'b1;
        @(negedge clk); ref_req = 1'b0;
        repeat (T_RP + 1) @(negedge clk);
        ref_req = 1'b1;
        #1 check(grant == 1'b0, "R6 no grant while busy", int'(grant), 0);
        @(negedge clk); ref_req = 1'b0;
        wait_idle();
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check(cmd == C_NOP && busy == 1'b0, "R6 dropped request", int'(cmd), int'(C_NOP));
        end

        // R7: self refresh refused with a bank open
        sr_req = 1'b1; bank_open = 1'b1;
        #1 check(grant == 1'b0, "R7 refused grant", int'(grant), 0);
        @(negedge clk);
        check(cmd == C_NOP && cke == 1'b1 && busy == 1'b0, "R7 refused bus", int'(cmd), int'(C_NOP));
        sr_req = 1'b0; bank_open = 1'b0;

        // R11: refresh wins over self refresh
        @(negedge clk);
        ref_req = 1'b1; sr_req = 1'b1;
        #1 check(grant == 1'b1, "R11 grant", int'(grant), 1);
        @(negedge clk);
        check(cmd == C_PRE && cke == 1'b1, "R11 precharge first", int'(cmd), int'(C_PRE));
        ref_req = 1'b0; sr_req = 1'b0;
        wait_idle();

        // R7 R8 R9 R10: self-refresh entry and exit
        @(negedge clk);
        sr_req = 1'b1; clk_stable = 1'b0;
        #1 check(grant == 1'b1, "R7 grant", int'(grant), 1);
        @(negedge clk);
        check(cmd == C_REF && cke == 1'b0, "R7 entry refresh", int'(cmd), int'(C_REF));
        check(reads_ok == 1'b0, "R10 reads blocked", int'(reads_ok), 0);
        repeat (8) @(negedge clk);
        check(cke == 1'b0, "R8 cke held low", int'(cke), 0);
        sr_req = 1'b0;
        repeat (4) @(negedge clk);
        check(cke == 1'b0, "R8 waits for clock", int'(cke), 0);
        clk_stable = 1'b1;
        @(negedge clk);
        check(cke == 1'b1 && cmd == C_NOP, "R8 cke rises", int'(cke), 1);
        for (int i = 1; i < T_XSNR; i++) begin
            @(negedge clk);
            check(cmd == C_NOP && cke == 1'b1, "R9 exit nop", int'(cmd), int'(C_NOP));
        end
        @(negedge clk);
        check(cmd == C_MODE, "R9 dll reset", int'(cmd), int'(C_MODE));
        @(negedge clk);
        check(busy == 1'b0 && cmd == C_NOP, "R9 idle after reset", int'(busy), 0);
        repeat (DLL_LOCK - 2) @(negedge clk);
        check(reads_ok == 1'b0, "R10 still blocked", int'(reads_ok), 0);
        @(negedge clk);
        check(reads_ok == 1'b1, "R10 reads allowed", int'(reads_ok), 1);

        // R1: reset in the middle of self refresh
        @(negedge clk); sr_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; sr_req = 1'b0;
        @(negedge clk);
        check(cke == 1'b1 && cmd == C_NOP, "R1 reset from self refresh", int'(cke), 1);
        check(busy == 1'b0 && reads_ok == 1'b1, "R1 reset flags", int'(reads_ok), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule